// File: doc/BRIEF.md
# Next Program Counter Selection

This block keeps the program counter of a 16-bit processor and works out its next value each time the controller lets it load. The next value comes from one of three places. In the fetch phase it is the counter plus one. For a branch or a register jump it comes from an address adder. For a service call it is a value taken from the shared data bus. If the counter is told to load while executing some other instruction, it keeps its value.

A conditional branch holds a three-bit mask in instr[11:9]. Each mask bit stands for one sign flag: bit 11 for negative, bit 10 for zero and bit 9 for positive. The mask is compared with the current one-hot flags. One instruction can therefore mean never, always, or any mix of signs.

The branch target is the counter, already advanced past the branch, plus the sign-extended nine-bit offset in instr[8:0]. A register jump loads the full value of the register chosen by instr[8:6], which the register file supplies on `reg_val`. A service call zero-extends the eight-bit vector in instr[7:0]. The result goes into a registered trap-address output that feeds the memory address register. The counter, the trap address and a "redirected" indicator are all registered.

Top module: `npc_select`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_q` becomes 0x3000, and `trap_addr` and `redirect_q` become 0.
- R2: A clock edge with `pc_ld` low leaves `pc_q`, `trap_addr` and `redirect_q` unchanged, whatever the instruction or the fetch input.
- R3: With `pc_ld` and `fetch` high, `pc_q` becomes `pc_q + 1` modulo 2^16, so 0xFFFF wraps to 0x0000.
- R4: With `pc_ld` high, `fetch` low and opcode instr[15:12]=0000, the branch is taken when any mask bit is set together with its flag. The pairs are instr[11] with flags[2] (negative), instr[10] with flags[1] (zero) and instr[9] with flags[0] (positive). When taken, `pc_q` becomes `pc_q` plus instr[8:0] sign-extended, modulo 2^16.
- R5: A branch whose mask shares no set bit with the flags leaves `pc_q` unchanged.
- R6: A branch mask of 000 is never taken and a mask of 111 is always taken, for any one-hot flag value.
- R7: With `pc_ld` high, `fetch` low and opcode 1100, `pc_q` becomes `reg_val`.
- R8: With `pc_ld` high, `fetch` low and opcode 1111, `pc_q` becomes `bus_val`, and `trap_addr` becomes instr[7:0] zero-extended to 16 bits.
- R9: With `pc_ld` high, `fetch` low and any other opcode, `pc_q` and `trap_addr` are unchanged.
- R10: On every loading edge, `redirect_q` becomes 1 for a taken branch, a register jump or a service call, and 0 for everything else, fetch included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_ld | input | 1 | Load enable for the counter |
| fetch | input | 1 | High in the fetch phase: select the increment |
| instr | input | 16 | Current instruction word |
| flags | input | 3 | One-hot sign flags {negative, zero, positive} |
| reg_val | input | 16 | Contents of the jump base register |
| bus_val | input | 16 | Value on the shared bus, used as the service-call target |
| pc_q | output | 16 | Program counter |
| trap_addr | output | 16 | Zero-extended service vector for the memory address register |
| redirect_q | output | 1 | Last load left the sequential path |

## Verification
The checker assumes the flag inputs are exactly one-hot whenever a branch is being evaluated, because the condition logic upstream always holds one sign. The bench therefore drives only 100, 010 and 001 as flags during branch cycles. It sets other flag values only with non-branch opcodes, where they cannot matter. Before each branch it uses a register jump to put the counter at a known base. This keeps each target within what the arithmetic model predicts, including the wrap at both ends of the address space.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_INC   = 2'd1,
    SRC_ADDER = 2'd2,
    SRC_BUS   = 2'd3
  } npc_src_e;

  localparam int unsigned OPW = 4;
  localparam logic [OPW-1:0] OP_BR   = 4'b0000;
  localparam logic [OPW-1:0] OP_JMP  = 4'b1100;
  localparam logic [OPW-1:0] OP_TRAP = 4'b1111;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval #(
  parameter int unsigned MASKW = 3
) (
  input  logic [MASKW-1:0] mask,
  input  logic [MASKW-1:0] flags,
  output logic             hit
);
  logic [MASKW-1:0] term;

  // One AND term per sign; any match takes the branch.
  for (genvar i = 0; i < MASKW; i++) begin : g_term
    assign term[i] = mask[i] & flags[i];
  end

  assign hit = |term;
endmodule

// File: rtl/npc_addr_adder.sv
module npc_addr_adder #(
  parameter int unsigned W    = 16,
  parameter int unsigned OFFW = 9
) (
  input  logic [W-1:0]    base,
  input  logic [OFFW-1:0] off,
  input  logic            use_off,
  output logic [W-1:0]    sum
);
  localparam int unsigned EXTW = W - OFFW;

  logic [W-1:0] off_ext;

  always_comb begin
    if (use_off) off_ext = {{EXTW{off[OFFW-1]}}, off};
    else         off_ext = '0;
  end

  assign sum = base + off_ext;
endmodule

// File: rtl/npc_src_mux.sv
module npc_src_mux
  import npc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  npc_src_e     sel,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] inc,
  input  logic [W-1:0] adder,
  input  logic [W-1:0] bus,
  output logic [W-1:0] nxt
);
  always_comb begin
    unique case (sel)
      SRC_INC:   nxt = inc;
      SRC_ADDER: nxt = adder;
      SRC_BUS:   nxt = bus;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned OFFW     = 9,
  parameter int unsigned VECW     = 8,
  parameter int unsigned MASKW    = 3,
  parameter logic [W-1:0] RESET_PC = 16'h3000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pc_ld,
  input  logic             fetch,
  input  logic [W-1:0]     instr,
  input  logic [MASKW-1:0] flags,
  input  logic [W-1:0]     reg_val,
  input  logic [W-1:0]     bus_val,
  output logic [W-1:0]     pc_q,
  output logic [W-1:0]     trap_addr,
  output logic             redirect_q
);
  localparam int unsigned MASK_MSB = W - OPW - 1;
  localparam int unsigned ZEXTW    = W - VECW;

  logic [OPW-1:0]   opcode;
  logic [MASKW-1:0] mask;
  logic [OFFW-1:0]  off;
  logic [W-1:0]     vec_ext;
  logic             cond_hit;
  logic             is_jmp;
  logic [W-1:0]     adder_base;
  logic [W-1:0]     adder_sum;
  logic [W-1:0]     pc_inc;
  logic [W-1:0]     pc_nxt;
  npc_src_e         sel;
  logic             redirect_d;

  assign opcode  = instr[W-1 -: OPW];
  assign mask    = instr[MASK_MSB -: MASKW];
  assign off     = instr[OFFW-1:0];
  assign vec_ext = {{ZEXTW{1'b0}}, instr[VECW-1:0]};
  assign is_jmp  = (opcode == OP_JMP);
  assign pc_inc  = pc_q + 1'b1;

  npc_cond_eval #(.MASKW(MASKW)) u_cond (
    .mask  (mask),
    .flags (flags),
    .hit   (cond_hit)
  );

  // Jumps pass the register through the adder with a zero offset.
  assign adder_base = is_jmp ? reg_val : pc_q;

  npc_addr_adder #(.W(W), .OFFW(OFFW)) u_adder (
    .base    (adder_base),
    .off     (off),
    .use_off (!is_jmp),
    .sum     (adder_sum)
  );

  always_comb begin
    sel        = SRC_HOLD;
    redirect_d = 1'b0;
    if (fetch) begin
      sel = SRC_INC;
    end else begin
      unique case (opcode)
        OP_BR: begin
          if (cond_hit) begin
            sel        = SRC_ADDER;
            redirect_d = 1'b1;
          end
        end
        OP_JMP: begin
          sel        = SRC_ADDER;
          redirect_d = 1'b1;
        end
        OP_TRAP: begin
          sel        = SRC_BUS;
          redirect_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  npc_src_mux #(.W(W)) u_mux (
    .sel   (sel),
    .cur   (pc_q),
    .inc   (pc_inc),
    .adder (adder_sum),
    .bus   (bus_val),
    .nxt   (pc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= RESET_PC;
      trap_addr  <= '0;
      redirect_q <= 1'b0;
    end else if (pc_ld) begin
      pc_q       <= pc_nxt;
      redirect_q <= redirect_d;
      if (!fetch && opcode == OP_TRAP) trap_addr <= vec_ext;
    end
  end
endmodule

// File: rtl/npc_select_chk.sv
module npc_select_chk
  import npc_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned OFFW  = 9,
  parameter int unsigned VECW  = 8,
  parameter int unsigned MASKW = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             pc_ld,
  input logic             fetch,
  input logic [W-1:0]     instr,
  input logic [MASKW-1:0] flags,
  input logic [W-1:0]     reg_val,
  input logic [W-1:0]     bus_val,
  input logic [W-1:0]     pc_q,
  input logic [W-1:0]     trap_addr,
  input logic             redirect_q
);
  logic [OPW-1:0]   op;
  logic [MASKW-1:0] m;
  logic             exec;
  logic [W-1:0]     rel;

  assign op   = instr[W-1 -: OPW];
  assign m    = instr[W-OPW-1 -: MASKW];
  assign exec = pc_ld && !fetch;
  assign rel  = {{(W-OFFW){instr[OFFW-1]}}, instr[OFFW-1:0]};

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !pc_ld |=> $stable(pc_q) && $stable(trap_addr) && $stable(redirect_q)); // R2
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
    pc_ld && fetch |=> pc_q == $past(pc_q) + 1'b1); // R3
  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    exec && op == OP_BR |-> $onehot(flags)); // R4
  AST_BR_TAKEN: assert property (@(posedge clk) disable iff (rst)
    exec && op == OP_BR && (m & flags) != '0 |=> pc_q == $past(pc_q) + $past(rel)); // R4
  AST_BR_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    exec && op == OP_BR && (m & flags) == '0 |=> $stable(pc_q)); // R5
  AST_BR_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    exec && op == OP_BR && $countones(m) == MASKW |=> redirect_q); // R6
  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    exec && op == OP_JMP |=> pc_q == $past(reg_val)); // R7
  AST_TRAP_TARGET: assert property (@(posedge clk) disable iff (rst)
    exec && op == OP_TRAP |=> pc_q == $past(bus_val)
      && trap_addr == {{(W-VECW){1'b0}}, $past(instr[VECW-1:0])}); // R8
  AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (rst)
    exec && op != OP_BR && op != OP_JMP && op != OP_TRAP
      |=> $stable(pc_q) && $stable(trap_addr) && !redirect_q); // R9
  AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (rst)
    pc_ld && fetch |=> !redirect_q); // R10
endmodule

bind npc_select npc_select_chk #(
  .W(W), .OFFW(OFFW), .VECW(VECW), .MASKW(MASKW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pc_ld      (pc_ld),
  .fetch      (fetch),
  .instr      (instr),
  .flags      (flags),
  .reg_val    (reg_val),
  .bus_val    (bus_val),
  .pc_q       (pc_q),
  .trap_addr  (trap_addr),
  .redirect_q (redirect_q)
);

// File: tb/npc_select_bench.sv
module npc_select_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pc_ld = 1'b0;
  logic        fetch = 1'b0;
  logic [15:0] instr = '0;
  logic [2:0]  flags = 3'b010;
  logic [15:0] reg_val = '0;
  logic [15:0] bus_val = '0;
  logic [15:0] pc_q;
  logic [15:0] trap_addr;
  logic        redirect_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  npc_select u_npc_select (
    .clk(clk), .rst(rst), .pc_ld(pc_ld), .fetch(fetch), .instr(instr),
    .flags(flags), .reg_val(reg_val), .bus_val(bus_val),
    .pc_q(pc_q), .trap_addr(trap_addr), .redirect_q(redirect_q)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic ld, input logic f, input logic [15:0] ins,
                      input logic [2:0] fl, input logic [15:0] rv, input logic [15:0] bv);
    @(negedge clk);
    pc_ld = ld; fetch = f; instr = ins; flags = fl; reg_val = rv; bus_val = bv;
    @(posedge clk);
    #1;
  endtask

  task automatic jump_to(input logic [15:0] a);
    step(1'b1, 1'b0, 16'hC000, 3'b010, a, 16'h0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int offs[6] = '{0, 1, -1, 255, -256, 100};
    logic [15:0] base, exp;
    logic tk;
    string tag;

    repeat (3) @(posedge clk);
    #1;
    chk("R1 pc", pc_q, 16'h3000);
    chk("R1 trap", trap_addr, 16'h0000);
    chk("R1 redirect", {15'b0, redirect_q}, 16'h0);
    @(negedge clk) rst = 1'b0;

    // R3 fetch increment and R10 sequential indicator
    step(1'b1, 1'b1, 16'hC000, 3'b010, 16'h1111, 16'h0);
    chk("R3 fetch", pc_q, 16'h3001);
    chk("R10 fetch", {15'b0, redirect_q}, 16'h0);

    // R7 register jumps
    foreach (offs[i]) begin
      logic [15:0] v;
      v = 16'h1234 * 16'(i) + 16'h8000 * 16'(i % 2);
      jump_to(v);
      chk("R7 jmp", pc_q, v);
      chk("R10 jmp", {15'b0, redirect_q}, 16'h1);
    end
    jump_to(16'hFFFF);
    step(1'b1, 1'b1, 16'h0000, 3'b010, 16'h0, 16'h0);
    chk("R3 wrap", pc_q, 16'h0000);

    // R4 R5 R6 branch sweep over masks, one-hot flags and offsets
    for (int m = 0; m < 8; m++) begin
      for (int fi = 0; fi < 3; fi++) begin
        foreach (offs[k]) begin
          logic [2:0] fl;
          fl   = 3'(1 << fi);
          base = 16'h4000 + 16'(m * 16'h0100) + 16'(fi * 16'h0010);
          jump_to(base);
          step(1'b1, 1'b0, {4'b0000, 3'(m), 9'(offs[k])}, fl, 16'hDEAD, 16'hBEEF);
          tk  = (3'(m) & fl) != 3'b000;
          exp = tk ? base + 16'(offs[k]) : base;
          if (m == 0 || m == 7) tag = "R6";
          else if (tk)          tag = "R4";
          else                  tag = "R5";
          chk({tag, " branch pc"}, pc_q, exp);
          chk("R10 branch", {15'b0, redirect_q}, {15'b0, tk});
        end
      end
    end
    jump_to(16'h0005);
    step(1'b1, 1'b0, {4'b0000, 3'b010, 9'h100}, 3'b010, 16'h0, 16'h0);
    chk("R4 low wrap", pc_q, 16'hFF05);
    jump_to(16'hFFF0);
    step(1'b1, 1'b0, {4'b0000, 3'b001, 9'h0FF}, 3'b001, 16'h0, 16'h0);
    chk("R4 high wrap", pc_q, 16'h00EF);

    // R8 every service vector
    for (int v = 0; v < 256; v++) begin
      logic [15:0] bv;
      bv = {8'(v), ~8'(v)};
      step(1'b1, 1'b0, {4'b1111, 4'(v), 8'(v)}, 3'b100, 16'h0, bv);
      chk("R8 pc", pc_q, bv);
      chk("R8 vector", trap_addr, {8'h00, 8'(v)});
    end

    // R9 other opcodes hold pc and trap address
    step(1'b1, 1'b0, 16'hF05A, 3'b100, 16'h0, 16'h7777);
    jump_to(16'h2222);
    for (int op = 1; op < 15; op++) begin
      if (op == 12) continue;
      step(1'b1, 1'b0, {4'(op), 12'hFFF}, 3'b111, 16'h9999, 16'h8888);
      chk("R9 pc", pc_q, 16'h2222);
      chk("R9 trap", trap_addr, 16'h005A);
      chk("R10 other", {15'b0, redirect_q}, 16'h0);
    end

    // R2 load enable low: nothing moves
    jump_to(16'h5555);
    step(1'b0, 1'b0, 16'hC000, 3'b010, 16'h1234, 16'h0);
    chk("R2 jmp", pc_q, 16'h5555);
    step(1'b0, 1'b0, 16'hF0AB, 3'b010, 16'h0, 16'h4321);
    chk("R2 trap pc", pc_q, 16'h5555);
    chk("R2 trap vec", trap_addr, 16'h005A);
    step(1'b0, 1'b1, 16'h0000, 3'b010, 16'h0, 16'h0);
    chk("R2 fetch", pc_q, 16'h5555);
    step(1'b0, 1'b0, {4'b0000, 3'b111, 9'h010}, 3'b001, 16'h0, 16'h0);
    chk("R2 branch", pc_q, 16'h5555);
    chk("R2 redirect", {15'b0, redirect_q}, 16'h1);

    // R1 reset mid-run
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 rerun pc", pc_q, 16'h3000);
    chk("R1 rerun trap", trap_addr, 16'h0000);
    chk("R1 rerun redirect", {15'b0, redirect_q}, 16'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule